// File: doc/BRIEF.md
# ECC Error Reporting Unit

This unit sits next to a SECDED read-check path and turns its per-read error strobes into level interrupts and readable error records. Each read that the checker finds to hold a correctable single-bit error pulses one input, and each read with an uncorrectable double-bit error pulses another. The address and transaction ID of that read come with the pulse. For each of the two error classes, the unit keeps a pending flag and one capture record.

If an error of a class arrives while that class is still pending, the unit does not overwrite the first record. It raises a separate overflow condition instead. Software sees the status and the captured details through a small APB3 register window. Software acknowledges each condition by writing a one to the clear register for that condition. Every condition has an enable bit. The corrected, uncorrected and overflow lines are each gated by their enable, and all three are ORed into one combined interrupt.

Top module: `ecc_err_report`

Register map (byte offsets):
- `0x00` CTRL: bits [2:0] are the enables for corrected, uncorrected and overflow.
- `0x04` STATUS: read-only, bits [2:0] are the matching pending flags.
- `0x08` corrected-error address.
- `0x0C` corrected-error ID.
- `0x10` uncorrected-error address.
- `0x14` uncorrected-error ID.
- `0x18`, `0x1C` and `0x20` are the clear registers for corrected, uncorrected and overflow.

## Requirements
- R1: A cycle with `ce_pulse` high sets the corrected pending flag (STATUS bit 0). While enabled, `irq_ce` is high from the following cycle.
- R2: A cycle with `ue_pulse` high sets the uncorrected pending flag (STATUS bit 1). While enabled, `irq_ue` is high from the following cycle.
- R3: When a corrected error is accepted into an idle class, its `err_addr` reads back at offset 0x08 and its `err_id` reads back at offset 0x0C, both zero-extended.
- R4: When an uncorrected error is accepted into an idle class, its `err_addr` reads back at offset 0x10 and its `err_id` reads back at offset 0x14, both zero-extended.
- R5: An error that arrives while its own class is still pending sets the overflow pending flag (STATUS bit 2), which drives `irq_ovf`. That class's captured address and ID stay unchanged.
- R6: Writing a value with bit 0 set to 0x18, 0x1C or 0x20 clears the corrected, uncorrected or overflow pending flag respectively. Writing a value with bit 0 clear has no effect. These three offsets read as zero.
- R7: If a clear and a new error of the same class fall in the same cycle, the class stays pending, the new error's details are captured, and no overflow is raised.
- R8: CTRL bits [2:0] gate `irq_ce`, `irq_ue` and `irq_ovf`. A disabled class still sets and holds its STATUS bit. CTRL resets to 0x7.
- R9: `irq_any` is high exactly when at least one of `irq_ce`, `irq_ue` or `irq_ovf` is high.
- R10: `pready` is always 1 and `pslverr` is always 0. Reads of unmapped offsets return zero.
- R11: After reset, STATUS, the four capture registers and all four interrupt outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ce_pulse | input | 1 | One-cycle strobe for a corrected single-bit error |
| ue_pulse | input | 1 | One-cycle strobe for an uncorrectable double-bit error |
| err_addr | input | ADDR_W | Address of the read that raised the strobe |
| err_id | input | ID_W | Transaction ID of that read |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | APB_AW | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, tied high |
| pslverr | output | 1 | APB error, tied low |
| irq_ce | output | 1 | Corrected-error interrupt |
| irq_ue | output | 1 | Uncorrected-error interrupt |
| irq_ovf | output | 1 | Overflow interrupt |
| irq_any | output | 1 | OR of the three interrupts |

## Verification
The assertions assume that `err_addr` and `err_id` are valid in any cycle in which either strobe is high. They also assume that APB accesses follow the setup-then-access order, with `paddr` and `pwdata` held through both phases. The bench drives every strobe for exactly one cycle, on the falling edge. It always runs an APB transfer as a setup cycle followed by one access cycle. The same-cycle clear-and-error case is built by lining up a strobe with the access phase of a clear write. That way the collision stays inside the legal APB sequence.

// File: rtl/ecc_rpt_pkg.sv
package ecc_rpt_pkg;
    localparam int NCLS = 2;          // corrected, uncorrected
    localparam int IDX_CE  = 0;
    localparam int IDX_UE  = 1;
    localparam int IDX_OVF = 2;

    localparam logic [7:0] OFS_CTRL    = 8'h00;
    localparam logic [7:0] OFS_STATUS  = 8'h04;
    localparam logic [7:0] OFS_CE_ADDR = 8'h08;
    localparam logic [7:0] OFS_CE_ID   = 8'h0C;
    localparam logic [7:0] OFS_UE_ADDR = 8'h10;
    localparam logic [7:0] OFS_UE_ID   = 8'h14;
    localparam logic [7:0] OFS_CLR_CE  = 8'h18;
    localparam logic [7:0] OFS_CLR_UE  = 8'h1C;
    localparam logic [7:0] OFS_CLR_OVF = 8'h20;

    typedef struct packed {
        logic [2:0] en;
    } ctl_t;

    typedef struct packed {
        logic pend;
    } ovf_t;
endpackage

// File: rtl/ecc_class_track.sv
module ecc_class_track #(
    parameter int ADDR_W = 32,
    parameter int ID_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              err_i,
    input  logic              clr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ID_W-1:0]   id_i,
    output logic              pend_o,
    output logic              ovf_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [ID_W-1:0]   id_o
);
    typedef struct packed {
        logic              pend;
        logic [ADDR_W-1:0] addr;
        logic [ID_W-1:0]   id;
    } trk_t;

    trk_t trk_d, trk_q;
    logic pend_eff;

    always_comb begin
        // a clear in this cycle makes the class look idle to a new error
        pend_eff   = trk_q.pend & ~clr_i;
        trk_d      = trk_q;
        trk_d.pend = pend_eff | err_i;
        if (err_i && !pend_eff) begin
            trk_d.addr = addr_i;
            trk_d.id   = id_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign pend_o = trk_q.pend;
    assign ovf_o  = err_i & pend_eff;
    assign addr_o = trk_q.addr;
    assign id_o   = trk_q.id;

    AST_ERR_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
        err_i |=> pend_o);                                      // R1
    AST_HOLD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !clr_i) |=> ($stable(addr_o) && $stable(id_o))); // R5
endmodule

// File: rtl/ecc_apb_regs.sv
module ecc_apb_regs
    import ecc_rpt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int ID_W   = 8,
    parameter int APB_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [APB_AW-1:0] paddr,
    input  logic [31:0]       pwdata,
    input  logic [2:0]        pend_i,
    input  logic [ADDR_W-1:0] ce_addr_i,
    input  logic [ID_W-1:0]   ce_id_i,
    input  logic [ADDR_W-1:0] ue_addr_i,
    input  logic [ID_W-1:0]   ue_id_i,
    output logic [2:0]        en_o,
    output logic [2:0]        clr_o,
    output logic [31:0]       prdata
);
    ctl_t ctl_d, ctl_q;
    logic wr_acc;

    assign wr_acc = psel & penable & pwrite;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_acc && paddr == APB_AW'(OFS_CTRL)) ctl_d.en = pwdata[2:0];
    end

    always_comb begin
        clr_o[IDX_CE]  = wr_acc && paddr == APB_AW'(OFS_CLR_CE)  && pwdata[0];
        clr_o[IDX_UE]  = wr_acc && paddr == APB_AW'(OFS_CLR_UE)  && pwdata[0];
        clr_o[IDX_OVF] = wr_acc && paddr == APB_AW'(OFS_CLR_OVF) && pwdata[0];
    end

    always_comb begin
        prdata = '0;
        if (psel && !pwrite) begin
            if      (paddr == APB_AW'(OFS_CTRL))    prdata = 32'(ctl_q.en);
            else if (paddr == APB_AW'(OFS_STATUS))  prdata = 32'(pend_i);
            else if (paddr == APB_AW'(OFS_CE_ADDR)) prdata = 32'(ce_addr_i);
            else if (paddr == APB_AW'(OFS_CE_ID))   prdata = 32'(ce_id_i);
            else if (paddr == APB_AW'(OFS_UE_ADDR)) prdata = 32'(ue_addr_i);
            else if (paddr == APB_AW'(OFS_UE_ID))   prdata = 32'(ue_id_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{en: 3'b111};
        else        ctl_q <= ctl_d;
    end

    assign en_o = ctl_q.en;

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !pwrite && paddr > APB_AW'(OFS_CLR_OVF)) |-> prdata == 32'd0); // R10
    AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && paddr == APB_AW'(OFS_CTRL)) |=> en_o == $past(pwdata[2:0])); // R8
endmodule

// File: rtl/ecc_err_report.sv
module ecc_err_report
    import ecc_rpt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int ID_W   = 8,
    parameter int APB_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_pulse,
    input  logic              ue_pulse,
    input  logic [ADDR_W-1:0] err_addr,
    input  logic [ID_W-1:0]   err_id,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [APB_AW-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    output logic              pready,
    output logic              pslverr,
    output logic              irq_ce,
    output logic              irq_ue,
    output logic              irq_ovf,
    output logic              irq_any
);
    logic [NCLS-1:0]   cls_err, cls_pend, cls_ovf;
    logic [ADDR_W-1:0] cls_addr [NCLS];
    logic [ID_W-1:0]   cls_id   [NCLS];
    logic [2:0]        en, clr, pend;
    ovf_t              ovf_d, ovf_q;

    assign cls_err[IDX_CE] = ce_pulse;
    assign cls_err[IDX_UE] = ue_pulse;

    for (genvar g = 0; g < NCLS; g++) begin : g_cls
        ecc_class_track #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_trk (
            .clk    (clk),
            .rst_n  (rst_n),
            .err_i  (cls_err[g]),
            .clr_i  (clr[g]),
            .addr_i (err_addr),
            .id_i   (err_id),
            .pend_o (cls_pend[g]),
            .ovf_o  (cls_ovf[g]),
            .addr_o (cls_addr[g]),
            .id_o   (cls_id[g])
        );
    end

    always_comb begin
        ovf_d      = ovf_q;
        ovf_d.pend = (ovf_q.pend & ~clr[IDX_OVF]) | (|cls_ovf);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ovf_q <= '0;
        else        ovf_q <= ovf_d;
    end

    assign pend = {ovf_q.pend, cls_pend};

    ecc_apb_regs #(.ADDR_W(ADDR_W), .ID_W(ID_W), .APB_AW(APB_AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .psel      (psel),
        .penable   (penable),
        .pwrite    (pwrite),
        .paddr     (paddr),
        .pwdata    (pwdata),
        .pend_i    (pend),
        .ce_addr_i (cls_addr[IDX_CE]),
        .ce_id_i   (cls_id[IDX_CE]),
        .ue_addr_i (cls_addr[IDX_UE]),
        .ue_id_i   (cls_id[IDX_UE]),
        .en_o      (en),
        .clr_o     (clr),
        .prdata    (prdata)
    );

    assign irq_ce  = pend[IDX_CE]  & en[IDX_CE];
    assign irq_ue  = pend[IDX_UE]  & en[IDX_UE];
    assign irq_ovf = pend[IDX_OVF] & en[IDX_OVF];
    assign irq_any = irq_ce | irq_ue | irq_ovf;
    assign pready  = 1'b1;
    assign pslverr = 1'b0;

    AST_OVF_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_pulse && cls_pend[IDX_CE] && !clr[IDX_CE]) |=> pend[IDX_OVF]); // R5
    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr[IDX_UE] && !ue_pulse) |=> !pend[IDX_UE]);                   // R6
    AST_CLR_LOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr[IDX_CE] && ce_pulse) |=> pend[IDX_CE]);                      // R7
    AST_UE_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
        ue_pulse |=> pend[IDX_UE]);                                       // R2
endmodule

// File: tb/ecc_err_report_bench.sv
module ecc_err_report_bench;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        ce_pulse = 0, ue_pulse = 0;
    logic [31:0] err_addr = 0;
    logic [7:0]  err_id = 0;
    logic        psel = 0, penable = 0, pwrite = 0;
    logic [7:0]  paddr = 0;
    logic [31:0] pwdata = 0;
    logic [31:0] prdata;
    logic        pready, pslverr, irq_ce, irq_ue, irq_ovf, irq_any;
    int          n_chk = 0, n_fail = 0;
    bit          done = 0;

    always #5 clk = ~clk;

    ecc_err_report u_ecc_err_report (
        .clk(clk), .rst_n(rst_n), .ce_pulse(ce_pulse), .ue_pulse(ue_pulse),
        .err_addr(err_addr), .err_id(err_id), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .irq_ce(irq_ce), .irq_ue(irq_ue),
        .irq_ovf(irq_ovf), .irq_any(irq_any)
    );

    // op: 0 write, 1 read-check, 2 inject corrected, 3 inject uncorrected,
    // 4 check irq lines {any,ovf,ue,ce}
    localparam int NV = 25;
    localparam logic [82:0] TBL [NV] = '{
        {3'd2, 8'h00, 32'h1000_0040, 32'h0000_0021, 8'd1},  // R1
        {3'd4, 8'h00, 32'h0,         32'h9,         8'd1},  // R1
        {3'd1, 8'h08, 32'h0,         32'h1000_0040, 8'd3},  // R3
        {3'd1, 8'h0C, 32'h0,         32'h21,        8'd3},  // R3
        {3'd1, 8'h04, 32'h0,         32'h1,         8'd1},  // R1
        {3'd2, 8'h00, 32'h0000_2000, 32'h0000_0005, 8'd5},  // R5
        {3'd4, 8'h00, 32'h0,         32'hD,         8'd5},  // R5, R9
        {3'd1, 8'h08, 32'h0,         32'h1000_0040, 8'd5},  // R5
        {3'd1, 8'h0C, 32'h0,         32'h21,        8'd5},  // R5
        {3'd1, 8'h04, 32'h0,         32'h5,         8'd5},  // R5
        {3'd0, 8'h18, 32'h1,         32'h0,         8'd6},  // R6
        {3'd1, 8'h04, 32'h0,         32'h4,         8'd6},  // R6
        {3'd0, 8'h20, 32'h1,         32'h0,         8'd6},  // R6
        {3'd4, 8'h00, 32'h0,         32'h0,         8'd6},  // R6
        {3'd3, 8'h00, 32'hABCD_0000, 32'h0000_007F, 8'd2},  // R2
        {3'd1, 8'h10, 32'h0,         32'hABCD_0000, 8'd4},  // R4
        {3'd1, 8'h14, 32'h0,         32'h7F,        8'd4},  // R4
        {3'd4, 8'h00, 32'h0,         32'hA,         8'd2},  // R2
        {3'd0, 8'h00, 32'h5,         32'h0,         8'd8},  // R8
        {3'd4, 8'h00, 32'h0,         32'h0,         8'd8},  // R8
        {3'd1, 8'h04, 32'h0,         32'h2,         8'd8},  // R8
        {3'd0, 8'h1C, 32'h0,         32'h0,         8'd6},  // R6 bit0 clear
        {3'd1, 8'h04, 32'h0,         32'h2,         8'd6},  // R6
        {3'd0, 8'h00, 32'h7,         32'h0,         8'd8},  // R8
        {3'd4, 8'h00, 32'h0,         32'hA,         8'd9}   // R9
    };

    task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
        @(negedge clk); penable = 1;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic apb_rd(input int req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
        @(negedge clk); penable = 1; #1;
        chk(req, prdata, exp);
        chk(10, {30'd0, pready, pslverr}, 32'h2);   // R10
        @(negedge clk); psel = 0; penable = 0;
    endtask

    task automatic inject(input bit ue, input logic [31:0] a, input logic [7:0] id);
        @(negedge clk); err_addr = a; err_id = id;
        if (ue) ue_pulse = 1; else ce_pulse = 1;
        @(negedge clk); ce_pulse = 0; ue_pulse = 0;
    endtask

    task automatic irq_chk(input int req, input logic [3:0] exp);
        @(negedge clk); #1;
        chk(req, {28'd0, irq_any, irq_ovf, irq_ue, irq_ce}, {28'd0, exp});
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R11 reset state
        irq_chk(11, 4'h0);
        apb_rd(11, 8'h04, 32'h0);
        apb_rd(11, 8'h08, 32'h0);
        apb_rd(11, 8'h14, 32'h0);
        apb_rd(8, 8'h00, 32'h7);              // R8 CTRL reset value

        for (int i = 0; i < NV; i++) begin
            logic [2:0]  op;
            logic [7:0]  a;
            logic [31:0] d, e;
            int          rq;
            {op, a, d, e} = TBL[i][82:8];
            rq = int'(TBL[i][7:0]);
            case (op)
                3'd0: apb_wr(a, d);
                3'd1: apb_rd(rq, a, e);
                3'd2: inject(1'b0, d, e[7:0]);
                3'd3: inject(1'b1, d, e[7:0]);
                default: irq_chk(rq, e[3:0]);
            endcase
        end

        apb_wr(8'h1C, 32'h1);
        irq_chk(6, 4'h0);                     // R6
        apb_rd(6, 8'h18, 32'h0);              // R6 clear regs read zero
        apb_rd(10, 8'h3C, 32'h0);             // R10 unmapped
        apb_rd(10, 8'h24, 32'h0);             // R10 unmapped

        // R7: clear and new corrected error in the same cycle
        inject(1'b0, 32'h0000_1111, 8'h01);
        @(negedge clk); psel = 1; pwrite = 1; paddr = 8'h18; pwdata = 32'h1;
        @(negedge clk); penable = 1; ce_pulse = 1; err_addr = 32'h0000_2222; err_id = 8'h02;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0; ce_pulse = 0;
        apb_rd(7, 8'h04, 32'h1);              // R7 pending, no overflow
        apb_rd(7, 8'h0C, 32'h02);             // R7 new details
        apb_rd(7, 8'h08, 32'h0000_2222);      // R7
        apb_wr(8'h18, 32'h1);

        // R1 R2 both classes in one cycle
        @(negedge clk); ce_pulse = 1; ue_pulse = 1; err_addr = 32'h0000_3300; err_id = 8'h33;
        @(negedge clk); ce_pulse = 0; ue_pulse = 0; #1;
        chk(1, {28'd0, irq_any, irq_ovf, irq_ue, irq_ce}, 32'hB);  // R1 R2
        apb_rd(4, 8'h10, 32'h0000_3300);      // R4
        apb_rd(3, 8'h0C, 32'h33);             // R3

        // R8 overflow disabled still records status
        apb_wr(8'h00, 32'h3);
        inject(1'b1, 32'h0000_4400, 8'h44);
        irq_chk(8, 4'hB);                     // R8 no irq_ovf
        apb_rd(8, 8'h04, 32'h7);              // R8
        apb_rd(5, 8'h10, 32'h0000_3300);      // R5 first kept
        apb_wr(8'h00, 32'h4);
        irq_chk(9, 4'hC);                     // R9 only overflow enabled
        apb_wr(8'h20, 32'h1);
        irq_chk(9, 4'h0);                     // R9

        done = 1;
        summary();
        $finish;
    end
endmodule